// File: doc/BRIEF.md
# Write-Through Four-Word-Line Cache Controller

This block is a direct-mapped data cache placed between a processor and main memory. Each line holds four 32-bit words. The four words share one valid bit and one tag. A processor read that finds its line valid and its tag matching gets the selected word in the same cycle, with no stall. Every store is passed straight on to a write-buffer port, so memory always holds the latest data (write-through). A store that misses first brings the whole line into the cache (write-allocate) and then writes its word.

On a miss the controller issues one refill request to memory. The request carries the address of the word the processor asked for. Memory returns the four words of the block one beat at a time, starting with the requested word and wrapping around the block. The processor is released as soon as its own word is stored (early restart), while the remaining beats continue to arrive.

The processor holds its request, address and data steady for as long as `cpuStall` is high. The access completes in the first cycle in which `cpuReq` is high and `cpuStall` is low.

Top module: `wt_block_cache`

## Requirements
- R1: A read whose line is valid, whose stored tag equals address bits [31:INDEX_W+4] and which finds the controller idle completes in the same cycle with no stall. `cpuRdata` is the word selected by address bits [3:2].
- R2: A miss raises `memRdReq` once. The request carries the byte address of the requested word, bits [1:0] zero. After the refill the other three words of the block read back from the cache as memory holds them.
- R3: The controller stores refill beats in wrap-around order. Beat k goes to word offset (requested offset + k) mod 4, so a request for offset 2 is filled as offsets 2, 3, 0, 1.
- R4: After a miss, the stalled access completes in the cycle after the beat that carries its own word. The remaining beats of the refill may still be outstanding at that point.
- R5: While a refill is open, two kinds of access stall: an access to the line being filled whose word has not yet arrived, and any access to another line until the last beat has been stored.
- R6: A store that completes writes its word into the cache and, in the same cycle, presents `memWrReq` with the word-aligned address and data. `memWrReq` is high only for a store whose word is available in the cache.
- R7: A store miss refills the line first and then writes the store word. A following read of that word hits and returns the stored data.
- R8: A store stalls for as long as `memWrReady` is low.
- R9: Address bits [1:0] are ignored. A store and a read that differ only in those bits reach the same word.
- R10: A `memRdValid` pulse arriving while no refill is open changes no cache contents.
- R11: After reset every line is invalid, so the first access to any line misses. `cpuStall` is low whenever `cpuReq` is low.
- R12: `memRdReq` is a single-cycle pulse, and there is exactly one per refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor access request |
| cpuWe | input | 1 | 1 = store, 0 = read |
| cpuAddr | input | 32 | Processor byte address |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Read data, valid when a read completes |
| cpuStall | output | 1 | Hold the current access |
| memRdReq | output | 1 | Refill request pulse |
| memRdAddr | output | 32 | Byte address of the first word to return |
| memRdValid | input | 1 | One refill beat is present |
| memRdData | input | 32 | Refill beat data |
| memWrReq | output | 1 | Write-through store presented to the write buffer |
| memWrAddr | output | 32 | Word-aligned store address |
| memWrData | output | 32 | Store data to memory |
| memWrReady | input | 1 | Write buffer accepts the store this cycle |

## Verification
The bench opens a refill on word offset 2 and then reads offsets 3, 0 and 1 back to back. A design that filled the line in linear order, or restarted the processor only after the last beat, would return the wrong word or stall for the wrong number of cycles. It sends a request to a different line while a refill is still open. A controller that did not hold that request would read a half-filled line or start a second refill. It also holds the write buffer busy during a store, evicts a line with a store to a conflicting tag, and pulses `memRdValid` while no refill is open. Faults there show up as lost write-through data, a missing refill, or corrupted words. A random run checks every cycle against a behavioural model backed by a golden memory image.

// File: rtl/wt_cache_pkg.sv
`timescale 1ns/1ps
package wt_cache_pkg;
  localparam int WORD_W = 32;
  localparam int OFF_W  = 2;

  typedef struct packed {
    logic             allocate;
    logic             beatWr;
    logic [OFF_W-1:0] beatOff;
    logic             storeWr;
  } dp_ctl_t;
endpackage

// File: rtl/wt_cache_datapath.sv
`timescale 1ns/1ps
module wt_cache_datapath
  import wt_cache_pkg::*;
#(
  parameter int INDEX_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dp_ctl_t            ctl,
  input  logic [29:0]        wordAddr,
  input  logic [WORD_W-1:0]  cpuWdata,
  input  logic [INDEX_W-1:0] fillIdx,
  input  logic [WORD_W-1:0]  memRdData,
  output logic               lineHit,
  output logic [WORD_W-1:0]  cpuRdata
);
  localparam int LINES = 1 << INDEX_W;
  localparam int WORDS = LINES * 4;
  localparam int TAG_W = 30 - INDEX_W - OFF_W;

  logic [LINES-1:0]   validQ;
  logic [TAG_W-1:0]   tagQ  [LINES];
  logic [WORD_W-1:0]  dataQ [WORDS];

  logic [INDEX_W-1:0] idx;
  logic [OFF_W-1:0]   off;
  logic [TAG_W-1:0]   tag;

  assign off = wordAddr[OFF_W-1:0];
  assign idx = wordAddr[OFF_W +: INDEX_W];
  assign tag = wordAddr[29 -: TAG_W];

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= '0;
    else if (ctl.allocate) validQ[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ctl.allocate) tagQ[idx] <= tag;
    if (ctl.beatWr) dataQ[{fillIdx, ctl.beatOff}] <= memRdData;
    if (ctl.storeWr) dataQ[{idx, off}] <= cpuWdata;
  end

  assign lineHit  = validQ[idx] && (tagQ[idx] == tag);
  assign cpuRdata = dataQ[{idx, off}];
endmodule

// File: rtl/wt_cache_control.sv
`timescale 1ns/1ps
module wt_cache_control
  import wt_cache_pkg::*;
#(
  parameter int INDEX_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuReq,
  input  logic               cpuWe,
  input  logic [29:0]        wordAddr,
  input  logic               lineHit,
  input  logic               memRdValid,
  input  logic               memWrReady,
  output dp_ctl_t            ctl,
  output logic [INDEX_W-1:0] fillIdx,
  output logic               cpuStall,
  output logic               memRdReq,
  output logic [31:0]        memRdAddr,
  output logic               memWrReq
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_FILL} state_t;

  state_t           stateQ;
  logic [27:0]      fillBlkQ;
  logic [OFF_W-1:0] fillOffQ;
  logic [OFF_W-1:0] beatCntQ;
  logic [3:0]       arrivedQ;

  logic [INDEX_W-1:0] idx;
  logic [OFF_W-1:0]   off;
  logic               wordReady;
  logic               accessOk;

  assign off     = wordAddr[OFF_W-1:0];
  assign idx     = wordAddr[OFF_W +: INDEX_W];
  assign fillIdx = fillBlkQ[INDEX_W-1:0];

  always_comb begin
    if (stateQ == S_IDLE) wordReady = lineHit;
    else wordReady = lineHit && (idx == fillIdx) && arrivedQ[off];
  end

  assign accessOk  = cpuReq && wordReady && (!cpuWe || memWrReady);
  assign cpuStall  = cpuReq && !accessOk;
  assign memWrReq  = cpuReq && cpuWe && wordReady;
  assign memRdReq  = (stateQ == S_REQ);
  assign memRdAddr = {fillBlkQ, fillOffQ, 2'b00};

  always_comb begin
    ctl.allocate = (stateQ == S_IDLE) && cpuReq && !lineHit;
    ctl.beatWr   = (stateQ == S_FILL) && memRdValid;
    ctl.beatOff  = fillOffQ + beatCntQ;
    ctl.storeWr  = accessOk && cpuWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      fillBlkQ <= '0;
      fillOffQ <= '0;
      beatCntQ <= '0;
      arrivedQ <= '0;
    end else begin
      case (stateQ)
        S_IDLE: if (ctl.allocate) begin
          fillBlkQ <= wordAddr[29:2];
          fillOffQ <= off;
          beatCntQ <= '0;
          arrivedQ <= '0;
          stateQ   <= S_REQ;
        end
        S_REQ: stateQ <= S_FILL;
        S_FILL: if (memRdValid) begin
          arrivedQ[ctl.beatOff] <= 1'b1;
          beatCntQ <= beatCntQ + 2'd1;
          if (beatCntQ == 2'd3) stateQ <= S_IDLE;
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wt_block_cache.sv
`timescale 1ns/1ps
module wt_block_cache
  import wt_cache_pkg::*;
#(
  parameter int INDEX_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic [31:0] cpuAddr,
  input  logic [31:0] cpuWdata,
  output logic [31:0] cpuRdata,
  output logic        cpuStall,
  output logic        memRdReq,
  output logic [31:0] memRdAddr,
  input  logic        memRdValid,
  input  logic [31:0] memRdData,
  output logic        memWrReq,
  output logic [31:0] memWrAddr,
  output logic [31:0] memWrData,
  input  logic        memWrReady
);
  dp_ctl_t            ctl;
  logic [INDEX_W-1:0] fillIdx;
  logic               lineHit;
  logic [29:0]        wordAddr;
  logic [1:0]         unusedByteOff;

  assign wordAddr      = cpuAddr[31:2];
  assign unusedByteOff = cpuAddr[1:0];
  assign memWrAddr     = {cpuAddr[31:2], 2'b00};
  assign memWrData     = cpuWdata;

  wt_cache_control #(.INDEX_W(INDEX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .wordAddr(wordAddr), .lineHit(lineHit), .memRdValid(memRdValid),
    .memWrReady(memWrReady), .ctl(ctl), .fillIdx(fillIdx),
    .cpuStall(cpuStall), .memRdReq(memRdReq), .memRdAddr(memRdAddr),
    .memWrReq(memWrReq)
  );

  wt_cache_datapath #(.INDEX_W(INDEX_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordAddr(wordAddr),
    .cpuWdata(cpuWdata), .fillIdx(fillIdx), .memRdData(memRdData),
    .lineHit(lineHit), .cpuRdata(cpuRdata)
  );
endmodule

// File: rtl/wt_block_cache_chk.sv
`timescale 1ns/1ps
module wt_block_cache_chk (
  input logic clk,
  input logic rstN,
  input logic cpuReq,
  input logic cpuWe,
  input logic cpuStall,
  input logic memRdReq,
  input logic memWrReq,
  input logic memWrReady
);
  AST_NO_STALL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReq |-> !cpuStall); // R11
  AST_RDREQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |=> !memRdReq); // R12
  AST_RDREQ_AFTER_MISS: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> $past(cpuReq && cpuStall)); // R2
  AST_STORE_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWe && !cpuStall) |-> (memWrReq && memWrReady)); // R6
  AST_WR_ONLY_STORE: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq |-> (cpuReq && cpuWe)); // R6
  AST_BUF_BUSY_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWe && !memWrReady) |-> cpuStall); // R8
  AST_FILL_OPEN_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && cpuReq) |-> cpuStall); // R5
endmodule

bind wt_block_cache wt_block_cache_chk chk_i (.*);

// File: tb/wt_block_cache_tb_top.sv
`timescale 1ns/1ps
module wt_block_cache_tb_top;
  localparam int IW = 4;
  localparam int LINES = 1 << IW;
  localparam int TW = 28 - IW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, cpuReq, cpuWe, cpuStall, memRdReq, memRdValid, memWrReq, memWrReady;
  logic [31:0] cpuAddr, cpuWdata, cpuRdata, memRdAddr, memRdData, memWrAddr, memWrData;

  wt_block_cache #(.INDEX_W(IW)) dut_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuStall(cpuStall),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .memWrReq(memWrReq), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memWrReady(memWrReady)
  );

  int checks = 0;
  int fails = 0;

  logic [31:0] gold [logic [29:0]];
  bit          mValid [LINES];
  logic [TW-1:0] mTag [LINES];
  int          mState = 0;
  int          fLine, fOff, fBeats;
  bit          arr [4];
  logic [31:0] fAddr;

  int          rspLeft = 0, rspDelay = 0, rspIdx = 0;
  logic [29:0] rspBase;
  bit          spurious = 0;
  int          rdReqCount = 0;

  bit          dReq = 0, dWe = 0, dWrReady = 1;
  logic [31:0] dAddr = '0, dWdata = '0;
  bit          lastExpStall;
  logic [31:0] lastRdata;
  int          lastState;

  function automatic logic [31:0] goldRd(logic [29:0] w);
    if (gold.exists(w)) return gold[w];
    return {2'b10, w};
  endfunction

  function automatic logic [31:0] mk(int tg, int ln, int off);
    logic [TW-1:0] t = TW'(tg);
    logic [IW-1:0] l = IW'(ln);
    logic [1:0]    o = 2'(off);
    return {t, l, o, 2'b00};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    bit beatNow;
    logic [IW-1:0] idx;
    logic [TW-1:0] tg;
    logic [1:0] off;
    bit hitL, ready, expStall;
    int st;
    @(negedge clk);
    cpuReq = dReq; cpuWe = dWe; cpuAddr = dAddr; cpuWdata = dWdata;
    memWrReady = dWrReady;
    beatNow = 0;
    if (rspLeft > 0 && rspDelay == 0) begin
      beatNow = 1;
      memRdValid = 1'b1;
      memRdData = goldRd({rspBase[29:2], 2'(rspBase[1:0] + 2'(rspIdx))});
    end else if (spurious) begin
      memRdValid = 1'b1; memRdData = 32'hDEAD_BEEF; spurious = 0;
    end else begin
      memRdValid = 1'b0; memRdData = '0;
    end
    #2;
    idx = dAddr[IW+3:4]; tg = dAddr[31:IW+4]; off = dAddr[3:2];
    hitL = mValid[idx] && (mTag[idx] == tg);
    ready = (mState == 0) ? hitL : (hitL && (int'(idx) == fLine) && arr[off]);
    expStall = dReq && !(ready && (!dWe || dWrReady));
    check(cpuStall == expStall, (mState == 0) ? "R1 stall" : "R5 stall", 32'(cpuStall), 32'(expStall));
    check(memRdReq == (mState == 1), "R12 rdreq", 32'(memRdReq), 32'(mState == 1));
    if (mState == 1) check(memRdAddr == fAddr, "R2 rdaddr", memRdAddr, fAddr);
    check(memWrReq == (dReq && dWe && ready), "R6 wrreq", 32'(memWrReq), 32'(dReq && dWe && ready));
    if (dReq && !dWe && !expStall)
      check(cpuRdata == goldRd(dAddr[31:2]), "R1 rdata", cpuRdata, goldRd(dAddr[31:2]));
    if (dReq && dWe && !expStall) begin
      check(memWrAddr == {dAddr[31:2], 2'b00}, "R6 wraddr", memWrAddr, {dAddr[31:2], 2'b00});
      check(memWrData == dWdata, "R6 wrdata", memWrData, dWdata);
      gold[dAddr[31:2]] = dWdata;
    end
    lastExpStall = expStall; lastRdata = cpuRdata; lastState = mState;
    st = mState;
    if (!rstN) mState = 0;
    else if (st == 2 && beatNow) begin
      arr[(fOff + fBeats) % 4] = 1; fBeats++;
      if (fBeats == 4) mState = 0;
    end else if (st == 1) mState = 2;
    else if (st == 0 && dReq && !hitL) begin
      mValid[idx] = 1; mTag[idx] = tg; fLine = int'(idx); fOff = int'(off); fBeats = 0;
      for (int k = 0; k < 4; k++) arr[k] = 0;
      fAddr = {dAddr[31:2], 2'b00}; mState = 1;
    end
    if (beatNow) begin
      rspIdx++; rspLeft--; rspDelay = (rspIdx == 1) ? 1 : 0;
    end else if (rspLeft > 0 && rspDelay > 0) rspDelay--;
    if (memRdReq) begin
      rspBase = memRdAddr[31:2]; rspIdx = 0; rspLeft = 4; rspDelay = 2; rdReqCount++;
    end
  endtask

  task automatic access(bit we, logic [31:0] addr, logic [31:0] wd, int wrLow,
                        output int stalls, output logic [31:0] rd, output int stDone);
    dReq = 1; dWe = we; dAddr = addr; dWdata = wd; stalls = 0;
    dWrReady = (wrLow == 0);
    forever begin
      tick();
      if (!lastExpStall) break;
      stalls++;
      if (stalls >= wrLow) dWrReady = 1;
    end
    rd = lastRdata; stDone = lastState; dReq = 0; dWrReady = 1;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finishRun();
  end

  initial begin
    int s, sd, rq;
    logic [31:0] rd;
    for (int i = 0; i < LINES; i++) mValid[i] = 0;
    rstN = 0; memRdValid = 0; memRdData = '0;
    repeat (3) tick();
    rstN = 1;
    tick();
    check(cpuStall == 0 && memRdReq == 0, "R11 reset idle", {cpuStall, memRdReq}, 0);

    // R11 / R4: cold miss on offset 2, early restart after first beat
    access(0, mk(1, 3, 2), 0, 0, s, rd, sd);
    check(s > 0, "R11 cold miss", s, 1);
    check(s == 5, "R4 restart latency", s, 5);
    check(sd == 2, "R4 fill still open", sd, 2);
    // R3: wrap order 3, 0, 1
    access(0, mk(1, 3, 3), 0, 0, s, rd, sd);
    check(s == 1, "R3 second beat offset 3", s, 1);
    access(0, mk(1, 3, 0), 0, 0, s, rd, sd);
    check(s == 0, "R3 third beat offset 0", s, 0);
    access(0, mk(1, 3, 1), 0, 0, s, rd, sd);
    check(rd == goldRd(mk(1, 3, 1) >> 2), "R2 whole block", rd, goldRd(mk(1, 3, 1) >> 2));
    check(rdReqCount == 1, "R12 one request", rdReqCount, 1);

    // R5: other line during an open refill
    access(0, mk(1, 5, 0), 0, 0, s, rd, sd);
    access(0, mk(1, 3, 1), 0, 0, s, rd, sd);
    check(sd == 0 && s > 0, "R5 other line waits", sd, 0);

    // R8 / R6: store hit with busy write buffer
    access(1, mk(1, 3, 2), 32'h1111_2222, 3, s, rd, sd);
    check(s == 3, "R8 buffer busy", s, 3);
    access(0, mk(1, 3, 2), 0, 0, s, rd, sd);
    check(rd == 32'h1111_2222 && s == 0, "R6 store hit", rd, 32'h1111_2222);

    // R7: store miss allocates
    rq = rdReqCount;
    access(1, mk(2, 3, 1), 32'h3333_4444, 0, s, rd, sd);
    check(rdReqCount == rq + 1 && s > 0, "R7 store miss refill", rdReqCount, rq + 1);
    repeat (4) tick();
    access(0, mk(2, 3, 1), 0, 0, s, rd, sd);
    check(rd == 32'h3333_4444 && s == 0, "R7 store word present", rd, 32'h3333_4444);
    access(0, mk(1, 3, 2), 0, 0, s, rd, sd);
    check(rd == 32'h1111_2222, "R6 memory holds store", rd, 32'h1111_2222);
    repeat (4) tick();

    // R9: byte offset ignored
    access(1, mk(2, 3, 0) | 32'h3, 32'h5555_6666, 0, s, rd, sd);
    repeat (4) tick();
    access(0, mk(2, 3, 0), 0, 0, s, rd, sd);
    check(rd == 32'h5555_6666, "R9 byte offset", rd, 32'h5555_6666);

    // R10: stray beat while idle
    rq = rdReqCount;
    spurious = 1;
    tick();
    access(0, mk(2, 3, 0), 0, 0, s, rd, sd);
    check(rd == 32'h5555_6666 && s == 0, "R10 stray beat ignored", rd, 32'h5555_6666);
    access(0, mk(2, 3, 1), 0, 0, s, rd, sd);
    check(rd == 32'h3333_4444 && rdReqCount == rq, "R10 line intact", rd, 32'h3333_4444);

    // random traffic against the model
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      a = mk($urandom_range(0, 2), $urandom_range(0, LINES - 1), $urandom_range(0, 3))
          | 32'($urandom_range(0, 3));
      access($urandom_range(0, 9) < 3, a, $urandom, $urandom_range(0, 2), s, rd, sd);
      if ($urandom_range(0, 4) == 0) tick();
    end
    repeat (8) tick();
    finishRun();
  end
endmodule